// File: doc/BRIEF.md
# Periodic DAC Trigger Sequencer

This block paces a DAC sample path. A single start event, taken from either a hardware trigger pin or a software strobe, begins a sequence. The start event itself emits the first conversion trigger. After it, the block emits further internal triggers at a fixed programmable spacing. Each trigger is a one-cycle pulse that advances the sample FIFO toward the converter.

The sequence ends in one of three ways. It can run out of its programmed trigger count. Software can drop the enable bit, in which case the block waits for the conversion already in flight to be acknowledged. A FIFO or soft reset aborts it at once. A programmed count of zero makes the run endless, so only the enable bit or a reset stops it. A completion flag records a graceful end, and that flag can raise an interrupt.

Top module: `periodic_trig_seq`

## Requirements
- R1: After reset, `trig_out`, `seq_done` and `irq` are all 0.
- R2: While idle and with `enable` at 1, a start event produces a `trig_out` pulse in the cycle after the event is sampled. The start source depends on `src_sel`: 1 takes `sw_strobe`, and 0 takes a rising edge of `hw_trig`. The source that is not selected is ignored, and any start event is ignored while `enable` is 0.
- R3: Consecutive triggers of one sequence are exactly `period`+1 clock cycles apart.
- R4: With `count` = N > 0, a sequence emits exactly N+1 triggers in total.
- R5: With `count` = 0, triggers continue without limit while `enable` stays 1.
- R6: Clearing `enable` during a sequence stops further triggers. If a triggered conversion has not yet seen `conv_done`, `seq_done` rises at the clock edge where `conv_done` is sampled high. Otherwise it rises at the next edge.
- R7: A `flush` pulse ends a running sequence at once: no further triggers are emitted, and `seq_done` is not set.
- R8: When a finite sequence ends, `seq_done` is set once its last conversion is acknowledged. A 1 on `done_clr` clears `seq_done`.
- R9: `irq` equals `seq_done` AND `irq_en`.
- R10: Start events that arrive while a sequence is running are ignored. They neither add triggers nor shift the spacing.
- R11: Each trigger is a single-cycle pulse. When `period` ≥ 1, `trig_out` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable; clearing it ends a sequence gracefully |
| period | input | 16 | Spacing between triggers minus one, in cycles |
| count | input | 16 | Number of internal triggers after the start; 0 = endless |
| src_sel | input | 1 | Start source: 1 software strobe, 0 hardware pin |
| hw_trig | input | 1 | Hardware start input (rising edge) |
| sw_strobe | input | 1 | Software start strobe, one cycle |
| flush | input | 1 | FIFO/soft reset, aborts a sequence |
| conv_done | input | 1 | Converter acknowledges a triggered conversion |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| done_clr | input | 1 | Write-one clear of the completion flag |
| trig_out | output | 1 | Conversion trigger pulse toward the sample FIFO |
| seq_done | output | 1 | Sequence completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench runs several period and count combinations and measures both the gap between triggers and their total number. An off-by-one in the period reload would show up as a gap of `period` or `period`+2 cycles, and a wrong count would show up as one trigger too many or too few.

Two tests target the corner cases of stopping. In the first, the enable bit is cleared while a conversion is still unacknowledged. A design that did not wait would raise the flag before `conv_done` arrives. In the second, a flush arrives mid-sequence. A design that drained instead of aborting would keep emitting triggers or would wrongly set the flag.

Further tests cover starts that must be ignored: events from the source that is not selected, events while disabled, and retriggers during a run. A design that accepted any of these would add pulses or restart the spacing.

// File: rtl/pts_pkg.sv
package pts_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } seq_state_e;
endpackage

// File: rtl/pts_start_sel.sv
module pts_start_sel #(
   parameter bit HW_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic hw_trig,
   input  logic sw_strobe,
   output logic start_req
);
   logic hw_event;

   generate
      if (HW_EDGE) begin : g_edge
         logic hw_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hw_prev <= 1'b0;
            else        hw_prev <= hw_trig;
         end
         assign hw_event = hw_trig & ~hw_prev;
      end else begin : g_level
         assign hw_event = hw_trig;
      end
   endgenerate

   assign start_req = src_sel ? sw_strobe : hw_event;
endmodule

// File: rtl/pts_period_timer.sv
module pts_period_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] period,
   input  logic         run,
   output logic         tick
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= period;
      else if (run && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);

   // R3: a loaded value starts the countdown from the programmed period
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(period));
endmodule

// File: rtl/pts_remaining_ctr.sv
module pts_remaining_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] count,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] rem;
   logic         endless;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem     <= '0;
         endless <= 1'b0;
      end else if (load) begin
         rem     <= count;
         endless <= (count == '0);
      end else if (dec && !endless) begin
         rem     <= rem - 1'b1;
      end
   end

   assign last = !endless && (rem == {{(W-1){1'b0}}, 1'b1});

   // R4: a finite run never decrements past zero
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec && !load |-> endless || rem != '0);
endmodule

// File: rtl/periodic_trig_seq.sv
module periodic_trig_seq #(
   parameter int PERIOD_W = 16,
   parameter int COUNT_W  = 16,
   parameter bit HW_EDGE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] period,
   input  logic [COUNT_W-1:0]  count,
   input  logic                src_sel,
   input  logic                hw_trig,
   input  logic                sw_strobe,
   input  logic                flush,
   input  logic                conv_done,
   input  logic                irq_en,
   input  logic                done_clr,
   output logic                trig_out,
   output logic                seq_done,
   output logic                irq
);
   import pts_pkg::*;

   generate
      if (PERIOD_W < 1 || PERIOD_W > 32) begin : g_bad_pw
         $error("PERIOD_W out of range");
      end
      if (COUNT_W < 1 || COUNT_W > 32) begin : g_bad_cw
         $error("COUNT_W out of range");
      end
   endgenerate

   seq_state_e state;
   logic start_req, start_ok, tick, last, fire, busy, done_set, trig_q, done_q;

   pts_start_sel #(.HW_EDGE(HW_EDGE)) i_start (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .hw_trig(hw_trig),
      .sw_strobe(sw_strobe), .start_req(start_req));

   assign start_ok = (state == ST_IDLE) && enable && start_req && !flush;
   assign fire     = (state == ST_RUN) && enable && tick && !flush;
   assign done_set = (state == ST_DRAIN) && (!busy || conv_done) && !flush;

   pts_period_timer #(.W(PERIOD_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(start_ok || fire), .period(period),
      .run(state == ST_RUN), .tick(tick));

   pts_remaining_ctr #(.W(COUNT_W)) i_remain (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .count(count),
      .dec(fire), .last(last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         busy   <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= start_ok || fire;
         if (flush) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
         end else begin
            if (start_ok || fire) busy <= 1'b1;
            else if (conv_done)   busy <= 1'b0;
            unique case (state)
               ST_IDLE:  if (start_ok) state <= ST_RUN;
               ST_RUN:   if (!enable || (fire && last)) state <= ST_DRAIN;
               ST_DRAIN: if (done_set) state <= ST_IDLE;
               default:  state <= ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
   end

   assign trig_out = trig_q;
   assign seq_done = done_q;
   assign irq      = done_q && irq_en;

   a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !trig_out && state == ST_IDLE);
   a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !enable |=> !trig_out);
   a_r6_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN) |=> !trig_out);
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr && !done_set |=> !seq_done);
endmodule

// File: tb/test_periodic_trig_seq.sv
module test_periodic_trig_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, src_sel = 1'b1, hw_trig = 1'b0, sw_strobe = 1'b0;
   logic flush = 1'b0, conv_done = 1'b1, irq_en = 1'b0, done_clr = 1'b0;
   logic [15:0] period = '0, count = '0;
   logic trig_out, seq_done, irq;

   always #2 clk = ~clk;

   periodic_trig_seq i_periodic_trig_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .count(count),
      .src_sel(src_sel), .hw_trig(hw_trig), .sw_strobe(sw_strobe), .flush(flush),
      .conv_done(conv_done), .irq_en(irq_en), .done_clr(done_clr),
      .trig_out(trig_out), .seq_done(seq_done), .irq(irq));

   int checks = 0, errors = 0;
   int cyc = 0, ntrig = 0, last_t = 0, badgap = 0, dbl = 0, exp_gap = 1;
   logic prev_trig = 1'b0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (trig_out) begin
         if (ntrig > 0 && cyc - last_t != exp_gap) badgap <= badgap + 1;
         if (prev_trig && exp_gap > 1) dbl <= dbl + 1;
         ntrig  <= ntrig + 1;
         last_t <= cyc;
      end
      prev_trig <= trig_out;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_mon();
      @(posedge clk); #1;
      ntrig = 0; badgap = 0; dbl = 0;
   endtask

   task automatic start(input logic use_sw);
      if (use_sw) sw_strobe = 1'b1; else hw_trig = 1'b1;
      step(1);
      sw_strobe = 1'b0; hw_trig = 1'b0;
   endtask

   // {src_sel, period, count}
   localparam logic [32:0] VEC [5] = '{
      {1'b1, 16'd3, 16'd2},
      {1'b0, 16'd0, 16'd4},
      {1'b1, 16'd7, 16'd1},
      {1'b0, 16'd2, 16'd5},
      {1'b1, 16'd1, 16'd3}
   };

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check(trig_out == 0, "R1 trig", trig_out, 0);
      check(seq_done == 0, "R1 done", seq_done, 0);
      check(irq == 0, "R1 irq", irq, 0);
      rst_n = 1'b1;
      step(2);

      // R2: ignored starts
      enable = 1'b1; src_sel = 1'b1; period = 16'd2; count = 16'd1;
      clear_mon(); start(1'b0); step(10);
      check(ntrig == 0, "R2 unselected hw", ntrig, 0);
      src_sel = 1'b0;
      clear_mon(); start(1'b1); step(10);
      check(ntrig == 0, "R2 unselected sw", ntrig, 0);
      enable = 1'b0; src_sel = 1'b1;
      clear_mon(); start(1'b1); step(10);
      check(ntrig == 0, "R2 disabled", ntrig, 0);
      enable = 1'b1;

      // R3 R4 R9 R11: vector table
      irq_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         src_sel = VEC[i][32]; period = VEC[i][31:16]; count = VEC[i][15:0];
         exp_gap = int'(period) + 1;
         clear_mon();
         start(src_sel);
         step((int'(count) + 1) * exp_gap + 10);
         check(ntrig == int'(count) + 1, "R4 trigger total", ntrig, int'(count) + 1);
         check(badgap == 0, "R3 spacing", badgap, 0);
         check(dbl == 0, "R11 single pulse", dbl, 0);
         check(seq_done == 1, "R8 done set", seq_done, 1);
         check(irq == 1, "R9 irq", irq, 1);
         done_clr = 1'b1; step(1); done_clr = 1'b0;
         check(seq_done == 0, "R8 done clear", seq_done, 0);
      end

      // R9: masked interrupt
      irq_en = 1'b0; src_sel = 1'b1; period = 16'd1; count = 16'd1; exp_gap = 2;
      clear_mon(); start(1'b1); step(12);
      check(seq_done == 1 && irq == 0, "R9 masked", irq, 0);
      done_clr = 1'b1; step(1); done_clr = 1'b0;

      // R10: retrigger ignored
      period = 16'd5; count = 16'd3; exp_gap = 6;
      clear_mon(); start(1'b1);
      for (int k = 0; k < 6; k++) begin step(2); start(1'b1); end
      step(20);
      check(ntrig == 4, "R10 retrigger count", ntrig, 4);
      check(badgap == 0, "R10 retrigger spacing", badgap, 0);
      done_clr = 1'b1; step(1); done_clr = 1'b0;

      // R5 R6: endless run then graceful stop with conversion pending
      conv_done = 1'b0; period = 16'd3; count = 16'd0; exp_gap = 4;
      clear_mon(); start(1'b1); step(60);
      check(ntrig >= 15, "R5 endless", ntrig, 15);
      check(badgap == 0, "R5 spacing", badgap, 0);
      enable = 1'b0;
      clear_mon(); step(20);
      check(ntrig == 0, "R6 no trig after disable", ntrig, 0);
      check(seq_done == 0, "R6 waits for conv_done", seq_done, 0);
      conv_done = 1'b1; step(1); conv_done = 1'b0;
      check(seq_done == 1, "R6 done on ack", seq_done, 1);
      done_clr = 1'b1; step(1); done_clr = 1'b0;
      enable = 1'b1; conv_done = 1'b1;

      // R7: flush aborts
      period = 16'd4; count = 16'd0; exp_gap = 5;
      clear_mon(); start(1'b1); step(12);
      flush = 1'b1; step(1); flush = 1'b0;
      clear_mon(); step(30);
      check(ntrig == 0, "R7 flush no trig", ntrig, 0);
      check(seq_done == 0, "R7 flush no flag", seq_done, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule